// File: doc/BRIEF.md
# BT.656 active video extractor

This block takes an 8-bit BT.656 byte stream, one byte per clock in which a byte-enable input is high, and returns only the active picture content. Each output pixel carries one luma value and the chroma pair it shares with its neighbour. Each pixel is also tagged with its field and with markers for the first pixel of a line and the first pixel of a field. Timing reference codes are checked for protection-bit consistency before they steer anything. The extractor stays silent after reset until it has seen field 0 vertical blanking and then the start of the first active line of field 0. From then on it walks through every active line of field 0, then every active line of field 1, and back again.

The block is built around a five-state sequencer. The states are `ST_SEEK` (searching after reset), `ST_ARM` (field 0 blanking seen), `ST_LINE` (taking samples), `ST_HGAP` (between lines of a field) and `ST_VGAP` (between fields). The transitions are:
- lock_arm: `ST_SEEK` to `ST_ARM` on any code with F=0 and V=1.
- lock_drop: `ST_ARM` to `ST_SEEK` on any code with F=1.
- lock_hit: `ST_ARM` to `ST_LINE` on a start-of-active-video code with F=0 and V=0.
- line_end: `ST_LINE` to `ST_HGAP` after the last pair of a line that is not the last line of the field.
- field_end: `ST_LINE` to `ST_VGAP` after the last pair of the last line of the field. This transition flips the field.
- line_start: `ST_HGAP` to `ST_LINE` on a start code with V=0 and the current F.
- field_start: `ST_VGAP` to `ST_LINE` on a start code with V=0 and the current F.

Geometry is chosen at elaboration by `MODE`. A separate detector watches for reference codes, and a pairing stage assembles and registers the pixels.

Top module: `bt656_extract`

## Requirements
- R1: A byte is consumed only on a rising edge with `byte_en` high. Bytes presented with `byte_en` low, including 0xFF and 0x00, leave reference-code matching and sample pairing untouched and never produce a pixel in the following cycle.
- R2: A reference code is 0xFF, 0x00, 0x00 followed by a status byte. In the status byte, bit 7 is 1, bit 6 is F, bit 5 is V, and bit 4 is H (0 = start of active video, 1 = end). Bits 3..0 must equal V^H, F^H, F^V and F^V^H. A status byte failing any of these checks is discarded.
- R3: After reset no pixel appears until a code with F=0, V=1 has been seen and is later followed by a start code with F=0, V=0. That line becomes line 0 of field 0. A code with F=1 seen before the start code restarts the search.
- R4: After a field's last active line, start codes are ignored until one arrives with the other F and V=0. Fields alternate 0, 1, 0, … and `pix_field` gives the F of the field the pixel belongs to.
- R5: `MODE`=0 sets `LINES_576` (default 288) active lines per field, and `MODE`=1 sets `LINES_480` (default 240). Every line holds `PIXELS` (default 720) pixels.
- R6: Active bytes are taken in the order Cb, Y0, Cr, Y1. The Y0 pixel is registered on the edge that samples Cr, and the Y1 pixel on the edge that samples Y1. Both pixels carry that group's Cb and Cr. So there is one pixel for every two enabled bytes, and never more than two valid cycles in a row.
- R7: No pixel is produced from horizontal blanking bytes or from lines whose codes have V=1.
- R8: A line ends after `PIXELS` pixels even if no end code follows. Bytes after that point are ignored until the next accepted start code.
- R9: `pix_sol` is high on the first pixel of each line. `pix_sof` is high on the first pixel of line 0 of each field. Both are low whenever `pix_vld` is low.
- R10: `rst_n` low (asynchronous) clears all outputs and returns the block to the search of R3. A field-1 line that follows a reset therefore yields nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| byte_en | input | 1 | Qualifies `vid_byte` in this cycle |
| vid_byte | input | 8 | BT.656 stream byte |
| pix_vld | output | 1 | Pixel outputs valid this cycle |
| pix_y | output | 8 | Luma sample |
| pix_cb | output | 8 | Blue-difference chroma shared by the pair |
| pix_cr | output | 8 | Red-difference chroma shared by the pair |
| pix_field | output | 1 | Field of the pixel (0 or 1) |
| pix_sof | output | 1 | First pixel of a field |
| pix_sol | output | 1 | First pixel of a line |

## Verification
The last Y1 byte of a line does two things on the same edge: it emits the final pixel, and it moves the sequencer into a gap state, flipping the field when the line is the field's last. The bench makes every line end this way. It then checks two things: that the final pixel still carries the old field, and that the first pixel after the gap carries the new field and both markers. Reference preambles are also split by disabled 0xFF and 0x00 junk bytes. So code detection and the byte-enable gating work on the same cycles. This case is judged by the exact pixel sequence from a scoreboard computed from the line, pair and field indices.

// File: rtl/bt656_pkg.sv
package bt656_pkg;

    typedef enum logic [2:0] {
        ST_SEEK,
        ST_ARM,
        ST_LINE,
        ST_HGAP,
        ST_VGAP
    } seq_state_e;

    typedef struct packed {
        logic f;
        logic v;
        logic h;
    } trs_flags_t;

    // protection bits of a status word must agree with F, V and H
    function automatic logic status_ok(input logic [7:0] s);
        return s[7]
            && (s[3] == (s[5] ^ s[4]))
            && (s[2] == (s[6] ^ s[4]))
            && (s[1] == (s[6] ^ s[5]))
            && (s[0] == (s[6] ^ s[5] ^ s[4]));
    endfunction

endpackage

// File: rtl/bt656_trs.sv
module bt656_trs
    import bt656_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       byte_en,
    input  logic [7:0] din,
    output logic       hit,
    output trs_flags_t flags
);
    // run: 0 idle, 1 seen FF, 2 seen FF 00, 3 seen FF 00 00
    logic [1:0] run_q;
    logic [1:0] run_d;

    always_comb begin
        if (din == 8'hFF)
            run_d = 2'd1;
        else if (din == 8'h00 && (run_q == 2'd1 || run_q == 2'd2))
            run_d = run_q + 2'd1;
        else
            run_d = 2'd0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            run_q <= 2'd0;
        else if (byte_en)
            run_q <= run_d;
    end

    assign hit     = byte_en && (run_q == 2'd3) && status_ok(din);
    assign flags.f = din[6];
    assign flags.v = din[5];
    assign flags.h = din[4];

endmodule

// File: rtl/bt656_seq.sv
module bt656_seq
    import bt656_pkg::*;
#(
    parameter int PAIRS       = 360,
    parameter int FIELD_LINES = 288
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hit,
    input  trs_flags_t flags,
    input  logic       y1_take,
    output logic       active,
    output logic       field,
    output logic       line0,
    output logic       pair0
);
    localparam int PW = (PAIRS > 2) ? $clog2(PAIRS) : 1;
    localparam int LW = (FIELD_LINES > 2) ? $clog2(FIELD_LINES) : 1;

    seq_state_e      state_q, state_d;
    logic [PW-1:0]   pair_q;
    logic [LW-1:0]   line_q;
    logic            field_q;

    logic sav, last_pair, last_line, lock_hit, line_end, field_end;

    assign sav       = hit && !flags.h;
    assign last_pair = (pair_q == PW'(PAIRS - 1));
    assign last_line = (line_q == LW'(FIELD_LINES - 1));
    assign lock_hit  = (state_q == ST_ARM) && sav && !flags.f && !flags.v;
    assign line_end  = (state_q == ST_LINE) && y1_take && last_pair && !last_line;
    assign field_end = (state_q == ST_LINE) && y1_take && last_pair && last_line;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SEEK: if (hit && !flags.f && flags.v) state_d = ST_ARM;
            ST_ARM: begin
                if (hit && flags.f)  state_d = ST_SEEK;
                else if (lock_hit)   state_d = ST_LINE;
            end
            ST_LINE: begin
                if (field_end)       state_d = ST_VGAP;
                else if (line_end)   state_d = ST_HGAP;
            end
            ST_HGAP: if (sav && !flags.v && flags.f == field_q) state_d = ST_LINE;
            ST_VGAP: if (sav && !flags.v && flags.f == field_q) state_d = ST_LINE;
            default: state_d = ST_SEEK;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_SEEK;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pair_q  <= '0;
            line_q  <= '0;
            field_q <= 1'b0;
        end else begin
            if (lock_hit) begin
                field_q <= 1'b0;
                line_q  <= '0;
            end else if (field_end) begin
                field_q <= ~field_q;
                line_q  <= '0;
            end else if (line_end) begin
                line_q  <= line_q + 1'b1;
            end
            if (state_q != ST_LINE)
                pair_q <= '0;
            else if (y1_take)
                pair_q <= last_pair ? '0 : pair_q + 1'b1;
        end
    end

    assign active = (state_q == ST_LINE);
    assign field  = field_q;
    assign line0  = (line_q == '0);
    assign pair0  = (pair_q == '0);

endmodule

// File: rtl/bt656_pair.sv
module bt656_pair (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       byte_en,
    input  logic [7:0] din,
    input  logic       active,
    input  logic       field,
    input  logic       line0,
    input  logic       pair0,
    output logic       y1_take,
    output logic       pix_vld,
    output logic [7:0] pix_y,
    output logic [7:0] pix_cb,
    output logic [7:0] pix_cr,
    output logic       pix_field,
    output logic       pix_sof,
    output logic       pix_sol
);
    logic [1:0] phase_q;
    logic [7:0] cb_q, y0_q, cr_q;
    logic       take;

    assign take    = byte_en && active;
    assign y1_take = take && (phase_q == 2'd3);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      phase_q <= 2'd0;
        else if (!active) phase_q <= 2'd0;
        else if (take)   phase_q <= phase_q + 2'd1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cb_q <= '0; y0_q <= '0; cr_q <= '0;
            pix_vld <= 1'b0; pix_y <= '0; pix_cb <= '0; pix_cr <= '0;
            pix_field <= 1'b0; pix_sof <= 1'b0; pix_sol <= 1'b0;
        end else begin
            pix_vld <= 1'b0;
            pix_sof <= 1'b0;
            pix_sol <= 1'b0;
            if (take) begin
                unique case (phase_q)
                    2'd0: cb_q <= din;
                    2'd1: y0_q <= din;
                    2'd2: begin
                        cr_q      <= din;
                        pix_vld   <= 1'b1;
                        pix_y     <= y0_q;
                        pix_cb    <= cb_q;
                        pix_cr    <= din;
                        pix_field <= field;
                        pix_sol   <= pair0;
                        pix_sof   <= pair0 && line0;
                    end
                    2'd3: begin
                        pix_vld   <= 1'b1;
                        pix_y     <= din;
                        pix_cb    <= cb_q;
                        pix_cr    <= cr_q;
                        pix_field <= field;
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/bt656_extract.sv
module bt656_extract
    import bt656_pkg::*;
#(
    parameter int MODE      = 0,
    parameter int PIXELS    = 720,
    parameter int LINES_576 = 288,
    parameter int LINES_480 = 240
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       byte_en,
    input  logic [7:0] vid_byte,
    output logic       pix_vld,
    output logic [7:0] pix_y,
    output logic [7:0] pix_cb,
    output logic [7:0] pix_cr,
    output logic       pix_field,
    output logic       pix_sof,
    output logic       pix_sol
);
    localparam int FIELD_LINES = (MODE == 1) ? LINES_480 : LINES_576;
    localparam int PAIRS       = PIXELS / 2;

    logic       hit, y1_take, active, field, line0, pair0;
    trs_flags_t flags;

    bt656_trs u_trs (
        .clk(clk), .rst_n(rst_n), .byte_en(byte_en), .din(vid_byte),
        .hit(hit), .flags(flags)
    );

    bt656_seq #(.PAIRS(PAIRS), .FIELD_LINES(FIELD_LINES)) u_seq (
        .clk(clk), .rst_n(rst_n), .hit(hit), .flags(flags), .y1_take(y1_take),
        .active(active), .field(field), .line0(line0), .pair0(pair0)
    );

    bt656_pair u_pair (
        .clk(clk), .rst_n(rst_n), .byte_en(byte_en), .din(vid_byte),
        .active(active), .field(field), .line0(line0), .pair0(pair0),
        .y1_take(y1_take), .pix_vld(pix_vld), .pix_y(pix_y), .pix_cb(pix_cb),
        .pix_cr(pix_cr), .pix_field(pix_field), .pix_sof(pix_sof), .pix_sol(pix_sol)
    );

endmodule

// File: rtl/bt656_extract_chk.sv
module bt656_extract_chk (
    input logic clk,
    input logic rst_n,
    input logic byte_en,
    input logic pix_vld,
    input logic pix_field,
    input logic pix_sof,
    input logic pix_sol
);
    // R1: a disabled byte cannot yield a pixel on the next cycle
    assert_disabled_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !byte_en |=> !pix_vld);

    // R6: the pairing never gives three valid cycles in a row
    assert_pair_burst_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_vld && $past(pix_vld)) |-> !$past(pix_vld, 2));

    // R4: back-to-back pixels belong to the same field
    assert_field_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_vld && $past(pix_vld)) |-> (pix_field == $past(pix_field)));

    // R9: field start is always also a line start on a valid pixel
    assert_sof_in_sol_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pix_sof |-> (pix_sol && pix_vld));

    // R9: markers are quiet without a pixel
    assert_marker_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_vld |-> !pix_sol);

    // R9: the pixel after a line start is never another line start
    assert_sol_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pix_sol |=> !pix_sol);

    // R10: outputs stay cleared while reset is held
    always @(posedge clk) begin
        if (!rst_n) begin
            assert_reset_clear_R10: assert (!pix_vld && !pix_sof && !pix_sol);
        end
    end

endmodule

bind bt656_extract bt656_extract_chk u_chk (
    .clk(clk), .rst_n(rst_n), .byte_en(byte_en), .pix_vld(pix_vld),
    .pix_field(pix_field), .pix_sof(pix_sof), .pix_sol(pix_sol)
);

// File: tb/sim_bt656_extract.sv
`timescale 1ns/1ps
module sim_bt656_extract;
    localparam int PIXELS = 8;
    localparam int PAIRS  = PIXELS / 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       byte_en = 1'b0;
    logic [7:0] vid_byte = 8'h00;
    logic       pix_vld, pix_field, pix_sof, pix_sol;
    logic [7:0] pix_y, pix_cb, pix_cr;

    int    checks = 0;
    int    fails  = 0;
    int    bcnt   = 0;
    bit    done   = 0;
    string cur_req = "R3";
    logic [26:0] exp_q[$];

    always #10 clk = ~clk;

    bt656_extract #(.MODE(1), .PIXELS(PIXELS), .LINES_576(3), .LINES_480(2)) u0 (
        .clk(clk), .rst_n(rst_n), .byte_en(byte_en), .vid_byte(vid_byte),
        .pix_vld(pix_vld), .pix_y(pix_y), .pix_cb(pix_cb), .pix_cr(pix_cr),
        .pix_field(pix_field), .pix_sof(pix_sof), .pix_sol(pix_sol)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] stat(input bit f, input bit v, input bit h);
        return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
    endfunction

    function automatic logic [7:0] bval(input int f, input int l, input int p, input int k);
        return 8'(32 + (f * 53 + l * 29 + p * 13 + k * 7) % 180);
    endfunction

    // scoreboard: every valid pixel is compared with the oldest expected one
    always @(posedge clk) begin
        #1;
        if (rst_n && pix_vld && !done) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, cur_req, "unexpected pixel y", int'(pix_y), 0);
            end else begin
                logic [26:0] e;
                e = exp_q.pop_front();
                chk(pix_y  == e[23:16], "R6", "luma",  int'(pix_y),  int'(e[23:16]));
                chk(pix_cb == e[15:8],  "R6", "cb",    int'(pix_cb), int'(e[15:8]));
                chk(pix_cr == e[7:0],   "R6", "cr",    int'(pix_cr), int'(e[7:0]));
                chk(pix_field == e[24], "R4", "field", int'(pix_field), int'(e[24]));
                chk(pix_sol == e[25],   "R9", "sol",   int'(pix_sol), int'(e[25]));
                chk(pix_sof == e[26],   "R9", "sof",   int'(pix_sof), int'(e[26]));
            end
        end
    end

    // every fifth byte is preceded by a disabled junk cycle (R1)
    task automatic send_byte(input logic [7:0] b);
        bcnt++;
        if (bcnt % 5 == 0) begin
            @(negedge clk);
            byte_en  = 1'b0;
            vid_byte = (bcnt % 2 == 1) ? 8'hFF : 8'h00;
        end
        @(negedge clk);
        byte_en  = 1'b1;
        vid_byte = b;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            byte_en  = 1'b0;
            vid_byte = 8'h00;
        end
    endtask

    task automatic send_trs(input bit f, input bit v, input bit h);
        send_byte(8'hFF); send_byte(8'h00); send_byte(8'h00); send_byte(stat(f, v, h));
    endtask

    task automatic send_line(input int f, input int v, input int l, input bit exp_on,
                             input bit omit_eav, input int extra);
        if (!omit_eav) send_trs(f[0], v[0], 1'b1);
        send_byte(8'h80); send_byte(8'h10); send_byte(8'h80); send_byte(8'h10);
        send_trs(f[0], v[0], 1'b0);
        for (int p = 0; p < PAIRS; p++) begin
            logic [7:0] cb, y0, cr, y1;
            cb = v ? 8'h80 : bval(f, l, p, 0);
            y0 = v ? 8'h10 : bval(f, l, p, 1);
            cr = v ? 8'h80 : bval(f, l, p, 2);
            y1 = v ? 8'h10 : bval(f, l, p, 3);
            send_byte(cb);
            send_byte(y0);
            if (exp_on) exp_q.push_back({(p == 0 && l == 0), (p == 0), f[0], y0, cb, cr});
            send_byte(cr);
            if (exp_on) exp_q.push_back({1'b0, 1'b0, f[0], y1, cb, cr});
            send_byte(y1);
        end
        for (int e = 0; e < extra; e++) send_byte(8'h5A);
    endtask

    task automatic drained(input string req);
        idle(4);
        chk(exp_q.size() == 0, req, "pixels still pending", exp_q.size(), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        idle(3);
        @(negedge clk);
        chk(!pix_vld && pix_y == 0 && !pix_sof && !pix_sol, "R10", "state in reset",
            int'(pix_vld), 0);
        rst_n = 1'b1;
        idle(2);
        chk(!pix_vld && pix_cb == 0 && pix_cr == 0, "R10", "state after reset",
            int'(pix_vld), 0);

        // R3: active lines before field-0 blanking must not lock
        cur_req = "R3";
        send_line(0, 0, 0, 0, 0, 0);
        send_line(0, 0, 1, 0, 0, 0);
        send_line(1, 1, 0, 0, 0, 0);
        send_line(1, 0, 0, 0, 0, 0);
        send_line(1, 0, 1, 0, 0, 0);
        drained("R3");

        // R2: corrupted status after arming is discarded; R7: blanking yields nothing
        cur_req = "R7";
        send_line(0, 1, 0, 0, 0, 0);
        cur_req = "R2";
        send_byte(8'hFF); send_byte(8'h00); send_byte(8'h00);
        send_byte(stat(1'b0, 1'b0, 1'b0) ^ 8'h01);
        for (int i = 0; i < 16; i++) send_byte(bval(0, 7, i, 1));
        cur_req = "R7";
        send_line(0, 1, 1, 0, 0, 0);
        drained("R2");

        // R3/R9: first active line of field 0 locks
        cur_req = "R3";
        send_line(0, 0, 0, 1, 0, 0);
        send_line(0, 0, 1, 1, 0, 0);
        drained("R3");

        // R5: a third field-0 line exceeds the field height and is dropped
        cur_req = "R5";
        send_line(0, 0, 2, 0, 0, 0);
        drained("R5");

        // R4: field 1 follows; R8: extra bytes after a full line, then no end code
        cur_req = "R7";
        send_line(0, 1, 0, 0, 0, 0);
        send_line(1, 1, 0, 0, 0, 0);
        cur_req = "R8";
        send_line(1, 0, 0, 1, 0, 6);
        send_line(1, 0, 1, 1, 1, 0);
        drained("R8");

        // R4: back to field 0
        cur_req = "R4";
        send_line(1, 1, 0, 0, 0, 0);
        send_line(0, 1, 0, 0, 0, 0);
        send_line(0, 0, 0, 1, 0, 0);
        send_line(0, 0, 1, 1, 0, 0);
        drained("R4");

        // R10: reset during field-1 blanking returns to search
        cur_req = "R10";
        send_trs(1'b1, 1'b1, 1'b1);
        send_byte(8'h80); send_byte(8'h10);
        @(negedge clk);
        rst_n = 1'b0;
        byte_en = 1'b0;
        exp_q.delete();
        idle(2);
        chk(!pix_vld && !pix_sof && pix_y == 0, "R10", "outputs during reset", int'(pix_vld), 0);
        rst_n = 1'b1;
        send_line(1, 0, 0, 0, 0, 0);
        send_line(1, 0, 1, 0, 0, 0);
        drained("R10");
        cur_req = "R3";
        send_line(0, 1, 0, 0, 0, 0);
        send_line(0, 0, 0, 1, 0, 0);
        send_line(0, 0, 1, 1, 0, 0);
        drained("R3");

        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule